// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block lets a processor drive an 8-bit NAND-style flash card one bus cycle at a time. Software loads a data byte, sets two 3-bit timing fields, and writes a 4-bit opcode. The sequencer then runs a command-latch, address-latch, write or read cycle on the card pins, with every phase counted in 10 ns clock cycles.

A full card operation is a chain of these opcodes. A read is command 00h, three address cycles, then data reads. A page program is command 80h, three address cycles, data writes, then confirm 10h. An erase is a setup command, two address cycles, then confirm D0h. The confirm variant of the command opcode waits for the card's ready/busy line to return high before the block goes idle, so software can issue status command 70h and one status read next. A timeout limits that wait and raises an error flag.

Software sees four flags: busy, a synchronized copy of the card's ready/busy line, read-data-valid, and the wait error.

Top module: `flash_seq`

## Requirements
- R1: During and right after reset, `we_n` and `re_n` are 1, `cle` and `ale` are 0, `dq` is released (high impedance), `seq_busy`, `rd_valid` and `wait_err` are 0, and `card_ready` is 1.
- R2: An opcode is accepted only when `op_valid` is high and `seq_busy` is 0. The codes are 1 = command, 2 = address, 3 = write data, 4 = read data, 5 = command then wait for ready, 6 = wait for ready. Codes 0 and 7 to 15 are ignored, and so is any `op_valid` while busy. An ignored opcode causes no strobe, no busy cycle and no change of `rd_valid`.
- R3: A bus cycle has three phases. The setup phase lasts M cycles, the strobe phase lasts P cycles, and the hold phase lasts M cycles, where M is `margin_len` and P is `strobe_len`, and a field of 0 counts as 1. For codes 1 to 4, `seq_busy` stays high for exactly 2M+P cycles.
- R4: Code 1 holds `cle` high and code 2 holds `ale` high for all 2M+P cycles. Each pulses `we_n` low for the P strobe cycles and drives the data byte on `dq`.
- R5: Code 3 keeps `cle` and `ale` low, pulses `we_n` low for P cycles and drives the data byte on `dq`.
- R6: Code 4 releases `dq`, pulses `re_n` low for P cycles, and captures `dq` in the last strobe cycle into `rd_byte`, setting `rd_valid`. `rd_valid` clears when the next opcode is accepted.
- R7: The byte driven on `dq` is the value `data_in` had when the opcode was accepted. Later changes to `data_in` are ignored.
- R8: After code 5 (following its command cycle) or on code 6, the block stays busy until the synchronized ready line is high. It stays busy for at least SYNC_STAGES+1 cycles of waiting in any case.
- R9: If ready does not return, the wait ends after exactly WAIT_LIMIT cycles with `wait_err` set. `wait_err` clears when the next opcode is accepted.
- R10: `card_ready` follows `rb_n` with a delay of SYNC_STAGES clock cycles.
- R11: `cle` and `ale` are never high together, `we_n` and `re_n` are never low together, and `dq` is never driven while `re_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns period |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode write strobe from software |
| op_code | input | 4 | Bus cycle opcode |
| data_in | input | 8 | Byte for command, address or write cycles |
| margin_len | input | 3 | Setup/hold length in cycles (0 counts as 1) |
| strobe_len | input | 3 | Strobe length in cycles (0 counts as 1) |
| rd_byte | output | 8 | Byte captured by the last read cycle |
| rd_valid | output | 1 | Read data present in `rd_byte` |
| seq_busy | output | 1 | A bus cycle or ready wait is in progress |
| card_ready | output | 1 | Synchronized copy of `rb_n` |
| wait_err | output | 1 | Last ready wait timed out |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| rb_n | input | 1 | Card ready (1) / busy (0) |
| dq | inout | 8 | Card data bus |

## Verification
The assertions assume that the card drives `dq` only while `re_n` is low, and that `rb_n` changes slowly compared with the synchronizer depth. The bench card model drives the bus only under `re_n` and moves `rb_n` only at falling clock edges, between whole opcode runs or during a wait. Timing fields stay constant while the block is busy, because the bench changes them only between opcodes.

// File: rtl/flash_seq_pkg.sv
// Package: shared opcode values and sequencer state type for flash_seq.
// Assumes: opcodes arrive on a 4-bit field; unlisted codes are invalid.
package flash_seq_pkg;
    localparam logic [3:0] OP_CMD      = 4'd1;
    localparam logic [3:0] OP_ADDR     = 4'd2;
    localparam logic [3:0] OP_WRITE    = 4'd3;
    localparam logic [3:0] OP_READ     = 4'd4;
    localparam logic [3:0] OP_CMD_WAIT = 4'd5;
    localparam logic [3:0] OP_WAIT     = 4'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_WAIT
    } seq_state_t;

    function automatic logic op_is_known(input logic [3:0] code);
        return (code >= OP_CMD) && (code <= OP_WAIT);
    endfunction
endpackage

// File: rtl/flash_sync.sv
// Module: flash_sync - a chain of flops that brings an asynchronous level
// into the clock domain. Assumes the input holds long enough to be seen.
// The output resets to RESET_VAL.
module flash_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the sampled level one stage further along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= (i == 0) ? async_in : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/flash_timer.sv
// Module: flash_timer - down counter for one bus-cycle phase. Loading a
// 3-bit field arms it for max(field,1) cycles; `last` is high in the final
// cycle of the phase. Assumes load is issued only when a phase begins.
module flash_timer #(
    parameter int FIELD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_val,
    output logic               last
);
    logic [FIELD_W-1:0] cnt;
    logic [FIELD_W-1:0] eff_val;

    // A zero field still gives the one-cycle minimum.
    assign eff_val = (load_val == '0) ? FIELD_W'(1) : load_val;

    // Load a new phase length or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= eff_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == FIELD_W'(1));

    // R3: a loaded phase never holds a zero length.
    assert_phase_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt != '0));
endmodule

// File: rtl/flash_seq.sv
// Module: flash_seq - runs one NAND card bus cycle per accepted opcode.
// Command, address, write and read cycles use a setup/strobe/hold phase
// pattern from two 3-bit timing fields. The wait opcodes poll the
// synchronized ready/busy line until it is high or a timeout expires.
// Assumes: timing fields are stable while busy; the card drives dq only
// while re_n is low.
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int FIELD_W     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int WAIT_LIMIT  = 4000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [3:0]         op_code,
    input  logic [DATA_W-1:0]  data_in,
    input  logic [FIELD_W-1:0] margin_len,
    input  logic [FIELD_W-1:0] strobe_len,
    output logic [DATA_W-1:0]  rd_byte,
    output logic               rd_valid,
    output logic               seq_busy,
    output logic               card_ready,
    output logic               wait_err,
    output logic               cle,
    output logic               ale,
    output logic               we_n,
    output logic               re_n,
    input  logic               rb_n,
    inout  wire  [DATA_W-1:0]  dq
);
    localparam int MIN_DWELL = SYNC_STAGES + 1;
    localparam int WCNT_W    = $clog2(WAIT_LIMIT + 1);

    seq_state_t         state;
    logic [3:0]         op_q;
    logic [DATA_W-1:0]  byte_q;
    logic [WCNT_W-1:0]  wait_cnt;
    logic               accept;
    logic               in_bus;
    logic               dq_oe;
    logic               tmr_load;
    logic [FIELD_W-1:0] tmr_val;
    logic               tmr_last;

    flash_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rb_n),
        .sync_out (card_ready)
    );

    flash_timer #(.FIELD_W(FIELD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    // Accept a known opcode only while idle.
    assign accept = op_valid && (state == ST_IDLE) && op_is_known(op_code);

    // Pick which timing field arms the next phase.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = margin_len;
        if (accept && op_code != OP_WAIT) begin
            tmr_load = 1'b1;
        end else if (state == ST_SETUP && tmr_last) begin
            tmr_load = 1'b1;
            tmr_val  = strobe_len;
        end else if (state == ST_STROBE && tmr_last) begin
            tmr_load = 1'b1;
        end
    end

    // Phase sequencing, wait polling and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= '0;
            byte_q   <= '0;
            wait_cnt <= '0;
            wait_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    op_q     <= op_code;
                    byte_q   <= data_in;
                    wait_cnt <= '0;
                    wait_err <= 1'b0;
                    state    <= (op_code == OP_WAIT) ? ST_WAIT : ST_SETUP;
                end
                ST_SETUP:  if (tmr_last) state <= ST_STROBE;
                ST_STROBE: if (tmr_last) state <= ST_HOLD;
                ST_HOLD:   if (tmr_last) state <= (op_q == OP_CMD_WAIT) ? ST_WAIT : ST_IDLE;
                ST_WAIT: begin
                    if (wait_cnt >= WCNT_W'(MIN_DWELL) && card_ready) begin
                        state <= ST_IDLE;
                    end else if (wait_cnt == WCNT_W'(WAIT_LIMIT - 1)) begin
                        wait_err <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture the card byte in the last read strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte  <= '0;
            rd_valid <= 1'b0;
        end else if (accept) begin
            rd_valid <= 1'b0;
        end else if (state == ST_STROBE && tmr_last && op_q == OP_READ) begin
            rd_byte  <= dq;
            rd_valid <= 1'b1;
        end
    end

    // Decode card pins from the phase and the latched opcode.
    assign in_bus   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    assign cle      = in_bus && (op_q == OP_CMD || op_q == OP_CMD_WAIT);
    assign ale      = in_bus && (op_q == OP_ADDR);
    assign we_n     = !(state == ST_STROBE && op_q != OP_READ);
    assign re_n     = !(state == ST_STROBE && op_q == OP_READ);
    assign dq_oe    = in_bus && (op_q != OP_READ);
    assign dq       = dq_oe ? byte_q : {DATA_W{1'bz}};
    assign seq_busy = (state != ST_IDLE);

    // R11: latch enables are exclusive.
    assert_latch_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R11: read and write strobes are exclusive.
    assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R11: the block never drives the bus while the card may.
    assert_bus_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);
    // R6: new read data only follows a read strobe.
    assert_read_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!re_n));
    // R9: an error appears only as the sequencer goes idle.
    assert_err_at_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_err) |-> !seq_busy);
    // R2: nothing starts without an opcode write.
    assert_start_needs_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> $past(op_valid));
endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;
    localparam int WLIM = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] data_in = '0;
    logic [2:0] margin_len = 3'd1;
    logic [2:0] strobe_len = 3'd1;
    logic [7:0] rd_byte;
    logic       rd_valid, seq_busy, card_ready, wait_err;
    logic       cle, ale, we_n, re_n;
    logic       rb_n = 1'b1;
    logic [7:0] card_byte = 8'h00;
    wire  [7:0] dq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // Card model: drives the bus only under its read strobe.
    assign dq = !re_n ? card_byte : 8'bz;

    always #5 clk = ~clk;

    flash_seq #(.WAIT_LIMIT(WLIM)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .data_in(data_in), .margin_len(margin_len), .strobe_len(strobe_len),
        .rd_byte(rd_byte), .rd_valid(rd_valid), .seq_busy(seq_busy),
        .card_ready(card_ready), .wait_err(wait_err), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .rb_n(rb_n), .dq(dq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one opcode, alter data_in afterwards, and measure the cycle.
    task automatic run_op(input logic [3:0] op, input logic [7:0] b,
                          output int len, output int n_cle, output int n_ale,
                          output int n_we, output int n_re, output int bad_bus);
        len = 0; n_cle = 0; n_ale = 0; n_we = 0; n_re = 0; bad_bus = 0;
        @(negedge clk);
        op_code = op; data_in = b; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0; data_in = ~b;
        while (seq_busy && len < 5000) begin
            len++;
            if (cle) n_cle++;
            if (ale) n_ale++;
            if (!we_n) begin
                n_we++;
                if (dq !== b) bad_bus++;
            end
            if (!re_n) n_re++;
            @(negedge clk);
        end
    endtask

    function automatic int eff(input logic [2:0] f);
        return (f == 3'd0) ? 1 : int'(f);
    endfunction

    // Stimulus table: {op, byte, margin, strobe}.
    localparam logic [17:0] VEC [8] = '{
        {4'd1, 8'h00, 3'd1, 3'd1},
        {4'd2, 8'h5A, 3'd2, 3'd3},
        {4'd3, 8'hC3, 3'd1, 3'd5},
        {4'd4, 8'hA7, 3'd2, 3'd2},
        {4'd1, 8'h80, 3'd0, 3'd0},
        {4'd3, 8'hFF, 3'd7, 3'd7},
        {4'd4, 8'h3C, 3'd0, 3'd4},
        {4'd2, 8'h01, 3'd3, 3'd1}
    };

    initial begin
        int len, nc, na, nw, nr, bad;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 we_n", int'(we_n), 1);
        chk("R1 re_n", int'(re_n), 1);
        chk("R1 cle|ale", int'(cle | ale), 0);
        chk("R1 dq released", int'(dq === 8'bz), 1);
        chk("R1 busy", int'(seq_busy), 0);
        chk("R1 card_ready", int'(card_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release rd_valid|err", int'(rd_valid | wait_err), 0);

        // Table walk: R3 length, R4/R5 latches and write strobe, R6 read, R7 byte.
        for (int i = 0; i < 8; i++) begin
            logic [3:0] op;
            logic [7:0] b;
            int m, p;
            op = VEC[i][17:14]; b = VEC[i][13:6];
            margin_len = VEC[i][5:3]; strobe_len = VEC[i][2:0];
            m = eff(margin_len); p = eff(strobe_len);
            card_byte = b;
            run_op(op, b, len, nc, na, nw, nr, bad);
            chk("R3 busy length", len, 2*m + p);
            chk("R4 cle cycles", nc, (op == 4'd1) ? 2*m + p : 0);
            chk("R4 ale cycles", na, (op == 4'd2) ? 2*m + p : 0);
            chk("R5 we_n low cycles", nw, (op == 4'd4) ? 0 : p);
            chk("R6 re_n low cycles", nr, (op == 4'd4) ? p : 0);
            chk("R7 driven byte", bad, 0);
            if (op == 4'd4) begin
                chk("R6 rd_valid", int'(rd_valid), 1);
                chk("R6 rd_byte", int'(rd_byte), int'(b));
            end else begin
                chk("R6 rd_valid cleared", int'(rd_valid), 0);
            end
        end

        // R2: invalid opcodes are ignored.
        margin_len = 3'd1; strobe_len = 3'd1;
        card_byte = 8'h99;
        run_op(4'd4, 8'h00, len, nc, na, nw, nr, bad);
        run_op(4'd9, 8'h12, len, nc, na, nw, nr, bad);
        chk("R2 invalid busy", len, 0);
        chk("R2 invalid strobes", nw + nr + nc + na, 0);
        chk("R2 rd_valid kept", int'(rd_valid), 1);
        run_op(4'd0, 8'h12, len, nc, na, nw, nr, bad);
        chk("R2 code 0 busy", len, 0);

        // R2: opcode while busy is ignored.
        margin_len = 3'd3; strobe_len = 3'd3;
        @(negedge clk);
        op_code = 4'd3; data_in = 8'h44; op_valid = 1'b1;
        @(negedge clk);
        op_code = 4'd4; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        nr = 0;
        for (int k = 0; k < 30; k++) begin
            if (!re_n) nr++;
            @(negedge clk);
        end
        chk("R2 busy ignores read", nr, 0);
        chk("R2 busy idle after", int'(seq_busy), 0);

        // R10: card_ready delay.
        rb_n = 1'b0;
        @(negedge clk);
        chk("R10 ready after 1 cycle", int'(card_ready), 1);
        @(negedge clk);
        chk("R10 ready after 2 cycles", int'(card_ready), 0);

        // R9: timeout on wait opcode and on command+wait.
        margin_len = 3'd2; strobe_len = 3'd3;
        run_op(4'd6, 8'h00, len, nc, na, nw, nr, bad);
        chk("R9 wait timeout length", len, WLIM);
        chk("R9 wait_err set", int'(wait_err), 1);
        run_op(4'd5, 8'h10, len, nc, na, nw, nr, bad);
        chk("R9 cmd+wait timeout length", len, 2*2 + 3 + WLIM);
        chk("R8 cmd+wait cle cycles", nc, 2*2 + 3);

        // R8: wait ends after ready returns; R9 err cleared on accept.
        fork
            run_op(4'd5, 8'hD0, len, nc, na, nw, nr, bad);
            begin
                repeat (20) @(negedge clk);
                rb_n = 1'b1;
            end
        join
        chk("R8 ends after ready", int'(len >= 19 && len <= 26), 1);
        chk("R9 err cleared", int'(wait_err), 0);

        // R8: minimum dwell with ready already high.
        run_op(4'd6, 8'h00, len, nc, na, nw, nr, bad);
        chk("R8 minimum dwell", len, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule